// File: doc/BRIEF.md
# Multi-drop UART receiver with address filtering

This block is the receive half of an asynchronous serial port on a shared multi-drop line. One master talks to many listeners over that line. Every frame carries a type flag: a one marks an address frame and a zero marks a data frame. With 9-bit characters the flag is the ninth data bit. With 5 to 8-bit characters the flag sits in the first stop-bit slot, and the sender appends a second stop bit that serves as the framing check.

A host-writable filter bit lets a listener that has not been addressed ignore data traffic. While the bit is set, only address frames reach the receive buffer. Once host logic sees its own address, it clears the bit and then takes in every frame.

Accepted words go into a small FIFO. The head of the FIFO is presented together with its type flag and framing status, and a read strobe removes it. The line is oversampled 16 times per bit, and a one-clock tick input paces the oversampling. The transmit side is not part of this block, so the filter bit has no effect on it.

Top module: `mdrop_rx`

## Requirements
- R1: When `filt_en` is 0 at frame end, every frame is stored and raises `rx_avail`, whatever its type flag.
- R2: When `filt_en` is 1 at frame end, a frame with type flag 0 is not stored. `rx_avail` stays 0 for it, and the FIFO contents are unchanged.
- R3: When `filt_en` is 1 at frame end, a frame with type flag 1 is stored and raises `rx_avail`.
- R4: With `char_sel` 4 to 7 (9 data bits), the ninth data bit is the type flag. It appears both on `rx_type` and as `rx_word[8]`.
- R5: With `char_sel` 0 to 3 (5 to 8 data bits, count = `char_sel`+5), the level in the first stop slot is the type flag. A low level in that slot never causes a framing error. `rx_word` bits at and above the data width read 0.
- R6: A low level in the final stop slot sets `frame_err` for that word. For 5 to 8-bit characters this is the second stop slot; for 9-bit characters it is the single stop slot.
- R7: The line idles high and data arrives LSB first. A start bit is confirmed by a majority of three samples taken at oversampling counts 7, 8 and 9. A low pulse that fails this vote stores nothing, and the receiver then takes the next frame normally.
- R8: The FIFO holds two words in arrival order, and `rd_en` removes the head. An accepted frame arriving while the FIFO is full, with no read in the same cycle, is dropped and sets `overrun`. A read clears `overrun`.
- R9: `filt_en` is sampled only at frame end. A change made in the middle of a frame decides the fate of that frame.
- R10: After reset `rx_avail` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| char_sel | input | 3 | Data width: 0-3 select 5-8 bits, 4-7 select 9 bits |
| filt_en | input | 1 | Address filter enable |
| rd_en | input | 1 | Remove head word from the FIFO |
| rx_word | output | 9 | Head word |
| rx_type | output | 1 | Type flag of head word (1 = address) |
| rx_avail | output | 1 | FIFO holds at least one word |
| frame_err | output | 1 | Framing error of head word |
| overrun | output | 1 | An accepted frame was lost to a full FIFO |

## Verification
A framer that slips its slot count would misplace the type flag. The result shows up at the port within that frame: `rx_avail` appears for filtered data frames or is missing for address frames, `rx_word` is shifted, or `frame_err` is raised wrongly. A stale filter sample would accept or drop the very frame whose middle saw the change. FIFO pointer or count faults show up at the second and third back-to-back frames as wrong order, a missing `overrun`, or `rx_avail` left high after the last read.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
  localparam int WORD_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_TYPE,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic              ferr;
    logic              typ;
    logic [WORD_W-1:0] word;
  } rx_entry_t;
endpackage

// File: rtl/mdrop_rx_vote.sv
module mdrop_rx_vote #(
  parameter int OSR   = 16,
  parameter int CNT_W = $clog2(OSR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             rxd,
  output logic             vote
);
  localparam logic [CNT_W-1:0] MID_LO = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] MID_HI = CNT_W'(OSR/2 + 1);

  logic [2:0] smp_q, smp_d;

  always_comb begin
    smp_d = smp_q;
    if (tick && (cnt >= MID_LO) && (cnt <= MID_HI)) begin
      smp_d = {smp_q[1:0], rxd};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= 3'b111;
    else        smp_q <= smp_d;
  end

  // two of three
  assign vote = (smp_q[0] & smp_q[1]) | (smp_q[0] & smp_q[2]) | (smp_q[1] & smp_q[2]);
endmodule

// File: rtl/mdrop_rx_framer.sv
module mdrop_rx_framer
  import mdrop_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int CNT_W = $clog2(OSR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic [2:0]        char_sel,
  input  logic              vote,
  output logic [CNT_W-1:0]  cnt,
  output logic              done,
  output logic [WORD_W-1:0] word,
  output logic              typ,
  output logic              ferr
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [3:0]        idx_q, idx_d;
  logic [3:0]        last_q, last_d;
  logic              nine_q, nine_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic              typ_q, typ_d;
  logic              ferr_q, ferr_d;
  logic              done_q, done_d;
  logic              slot_end;

  assign slot_end = tick && (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    last_d  = last_q;
    nine_d  = nine_q;
    shreg_d = shreg_q;
    typ_d   = typ_q;
    ferr_d  = ferr_q;
    done_d  = 1'b0;
    if (tick) cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (tick && !rxd) begin
          state_d = ST_START;
          cnt_d   = CNT_W'(1);
          shreg_d = '0;
          nine_d  = (char_sel >= 3'd4);
          last_d  = (char_sel >= 3'd4) ? 4'd8 : (4'(char_sel) + 4'd4);
        end
      end
      ST_START: begin
        if (slot_end) begin
          state_d = vote ? ST_IDLE : ST_DATA;
          idx_d   = '0;
        end
      end
      ST_DATA: begin
        if (slot_end) begin
          shreg_d[idx_q] = vote;
          if (idx_q == last_q) begin
            if (nine_q) begin
              typ_d   = vote;
              state_d = ST_STOP;
            end else begin
              state_d = ST_TYPE;
            end
          end else begin
            idx_d = idx_q + 4'd1;
          end
        end
      end
      ST_TYPE: begin
        if (slot_end) begin
          typ_d   = vote;
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (slot_end) begin
          ferr_d  = !vote;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= 4'd7;
      nine_q  <= 1'b0;
      shreg_q <= '0;
      typ_q   <= 1'b0;
      ferr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      nine_q  <= nine_d;
      shreg_q <= shreg_d;
      typ_q   <= typ_d;
      ferr_q  <= ferr_d;
      done_q  <= done_d;
    end
  end

  assign cnt  = cnt_q;
  assign done = done_q;
  assign word = shreg_q;
  assign typ  = typ_q;
  assign ferr = ferr_q;
endmodule

// File: rtl/mdrop_rx_fifo.sv
module mdrop_rx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 11,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] fill
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] fill_q, fill_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_en;
    assign wr_en = push && (wr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (wr_en) mem_q[i] <= din;
    end
  end

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    fill_d = fill_q;
    if (push) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + PTR_W'(1);
    if (pop)  rd_d = (rd_q == PTR_LAST) ? '0 : rd_q + PTR_W'(1);
    if (push && !pop)      fill_d = fill_q + CNT_W'(1);
    else if (pop && !push) fill_d = fill_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      fill_q <= fill_d;
    end
  end

  assign dout  = mem_q[rd_q];
  assign empty = (fill_q == '0);
  assign full  = (fill_q == CNT_FULL);
  assign fill  = fill_q;
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              os_tick,
  input  logic [2:0]        char_sel,
  input  logic              filt_en,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_type,
  output logic              rx_avail,
  output logic              frame_err,
  output logic              overrun
);
  localparam int CNT_W  = $clog2(OSR);
  localparam int ENT_W  = $bits(rx_entry_t);
  localparam int FILL_W = $clog2(FIFO_DEPTH + 1);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // line synchronizer
  logic [SYNC_STAGES-1:0] sync_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sync_q <= '1;
    else             sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end

  logic              line_s;
  logic [CNT_W-1:0]  fr_cnt;
  logic              fr_vote;
  logic              fr_done;
  logic [WORD_W-1:0] fr_word;
  logic              fr_typ;
  logic              fr_ferr;
  assign line_s = sync_q[SYNC_STAGES-1];

  mdrop_rx_vote #(.OSR(OSR), .CNT_W(CNT_W)) u_vote (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .tick (os_tick),
    .cnt  (fr_cnt),
    .rxd  (line_s),
    .vote (fr_vote)
  );

  mdrop_rx_framer #(.OSR(OSR), .CNT_W(CNT_W)) u_framer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (os_tick),
    .rxd     (line_s),
    .char_sel(char_sel),
    .vote    (fr_vote),
    .cnt     (fr_cnt),
    .done    (fr_done),
    .word    (fr_word),
    .typ     (fr_typ),
    .ferr    (fr_ferr)
  );

  // filter and buffer admission
  logic              accept, rd_go, push, drop;
  logic              fifo_empty, fifo_full;
  logic [FILL_W-1:0] fill;
  rx_entry_t         ent_in, ent_out;
  logic              ovr_q, ovr_d;

  assign accept = fr_done && (!filt_en || fr_typ);
  assign rd_go  = rd_en && !fifo_empty;
  assign push   = accept && (!fifo_full || rd_go);
  assign drop   = accept && fifo_full && !rd_go;
  assign ent_in = '{ferr: fr_ferr, typ: fr_typ, word: fr_word};

  mdrop_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .push (push),
    .din  (ent_in),
    .pop  (rd_go),
    .dout (ent_out),
    .empty(fifo_empty),
    .full (fifo_full),
    .fill (fill)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (drop)       ovr_d = 1'b1;
    else if (rd_go) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ovr_q <= 1'b0;
    else             ovr_q <= ovr_d;
  end

  assign rx_word   = ent_out.word;
  assign rx_type   = ent_out.typ;
  assign frame_err = ent_out.ferr;
  assign rx_avail  = !fifo_empty;
  assign overrun   = ovr_q;
endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk #(
  parameter int DEPTH  = 2,
  parameter int FILL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fr_done,
  input logic              fr_typ,
  input logic              filt_en,
  input logic              rd_go,
  input logic              fifo_full,
  input logic [FILL_W-1:0] fill,
  input logic              rx_avail,
  input logic              overrun
);
  // R2
  filt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && filt_en && !fr_typ && !rd_go) |=> $stable(fill));

  // R1 R3
  accept_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && (!filt_en || fr_typ) && !fifo_full && !rd_go) |=> (fill == $past(fill) + FILL_W'(1)));

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(DEPTH));

  // R8
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(fr_done && fifo_full && !rd_go));

  // R7
  avail_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_avail) |-> $past(fr_done));
endmodule

bind mdrop_rx mdrop_rx_chk #(.DEPTH(FIFO_DEPTH), .FILL_W(FILL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .fr_done  (fr_done),
  .fr_typ   (fr_typ),
  .filt_en  (filt_en),
  .rd_go    (rd_go),
  .fifo_full(fifo_full),
  .fill     (fill),
  .rx_avail (rx_avail),
  .overrun  (overrun)
);

// File: tb/mdrop_rx_tb.sv
module mdrop_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rxd;
  logic       os_tick = 1'b0;
  logic [2:0] char_sel;
  logic       filt_en;
  logic       rd_en;
  logic [8:0] rx_word;
  logic       rx_type, rx_avail, frame_err, overrun;

  int n_cmp = 0;
  int n_bad = 0;

  mdrop_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
    .char_sel(char_sel), .filt_en(filt_en), .rd_en(rd_en),
    .rx_word(rx_word), .rx_type(rx_type), .rx_avail(rx_avail),
    .frame_err(frame_err), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) os_tick = ~os_tick;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_wait();
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input int nb, input logic [8:0] data, input logic tflag, input logic stop_ok);
    rxd = 1'b0;
    bit_wait();
    for (int i = 0; i < nb; i++) begin
      rxd = (nb == 9 && i == 8) ? tflag : data[i];
      bit_wait();
    end
    if (nb < 9) begin
      rxd = tflag;
      bit_wait();
    end
    rxd = stop_ok;
    bit_wait();
    rxd = 1'b1;
    bit_wait();
    bit_wait();
  endtask

  function automatic logic [8:0] exp_word(input int nb, input logic [8:0] data, input logic tflag);
    if (nb == 9) return {tflag, data[7:0]};
    return data & 9'((1 << nb) - 1);
  endfunction

  task automatic pop_expect(input string req, input logic [8:0] w, input logic t, input logic fe);
    check({req, " avail"}, 32'(rx_avail), 32'(1));
    check({req, " word"}, 32'(rx_word), 32'(w));
    check({req, " type"}, 32'(rx_type), 32'(t));
    check({req, " ferr"}, 32'(frame_err), 32'(fe));
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_empty(input string req);
    check({req, " no word"}, 32'(rx_avail), 32'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; char_sel = 3'd3; filt_en = 1'b0; rd_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R10 reset state
    check("R10 avail", 32'(rx_avail), 32'(0));
    check("R10 overrun", 32'(overrun), 32'(0));

    // sweep character sizes and patterns with filter off and on
    for (int nb = 5; nb <= 9; nb++) begin
      char_sel = 3'(nb - 5);
      for (int v = 0; v < 3; v++) begin
        logic [8:0] pat;
        pat = 9'((v * 149 + nb * 23 + 90) % 512);
        filt_en = 1'b0;
        send_frame(nb, pat, 1'b0, 1'b1);
        pop_expect(nb == 9 ? "R1 R4 data" : "R1 R5 data", exp_word(nb, pat, 1'b0), 1'b0, 1'b0);
        filt_en = 1'b1;
        send_frame(nb, pat ^ 9'h0F3, 1'b0, 1'b1);
        expect_empty("R2 filtered data");
        send_frame(nb, pat, 1'b1, 1'b1);
        pop_expect(nb == 9 ? "R3 R4 addr" : "R3 R5 addr", exp_word(nb, pat, 1'b1), 1'b1, 1'b0);
        expect_empty("R3 single word");
      end
    end

    // R4 with 9-bit select code beyond 4
    filt_en = 1'b0;
    char_sel = 3'd7;
    send_frame(9, 9'h0C3, 1'b1, 1'b1);
    pop_expect("R4 code7", 9'h1C3, 1'b1, 1'b0);

    // R6 framing errors
    char_sel = 3'd3;
    send_frame(8, 9'h03C, 1'b0, 1'b0);
    pop_expect("R6 8bit", 9'h03C, 1'b0, 1'b1);
    char_sel = 3'd4;
    send_frame(9, 9'h066, 1'b1, 1'b0);
    pop_expect("R6 9bit", 9'h166, 1'b1, 1'b1);

    // R7 false start then normal frame
    char_sel = 3'd3;
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    bit_wait(); bit_wait();
    expect_empty("R7 glitch");
    send_frame(8, 9'h0A9, 1'b0, 1'b1);
    pop_expect("R7 recovery", 9'h0A9, 1'b0, 1'b0);

    // R8 overrun and order
    send_frame(8, 9'h011, 1'b0, 1'b1);
    send_frame(8, 9'h022, 1'b1, 1'b1);
    check("R8 no overrun yet", 32'(overrun), 32'(0));
    send_frame(8, 9'h033, 1'b0, 1'b1);
    check("R8 overrun set", 32'(overrun), 32'(1));
    pop_expect("R8 first", 9'h011, 1'b0, 1'b0);
    check("R8 overrun cleared", 32'(overrun), 32'(0));
    pop_expect("R8 second", 9'h022, 1'b1, 1'b0);
    expect_empty("R8 third dropped");

    // R9 filter bit sampled at frame end
    filt_en = 1'b0;
    fork
      send_frame(8, 9'h05E, 1'b0, 1'b1);
      begin repeat (5 * BIT_CLKS) @(negedge clk); filt_en = 1'b1; end
    join
    expect_empty("R9 set mid-frame");
    fork
      send_frame(8, 9'h0E5, 1'b0, 1'b1);
      begin repeat (3 * BIT_CLKS) @(negedge clk); filt_en = 1'b0; end
    join
    pop_expect("R9 cleared mid-frame", 9'h0E5, 1'b0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule